// File: doc/BRIEF.md
# Dual-Scan Passive LCD Timing Controller

This block turns a pixel stream into the timing a split-screen monochrome passive panel needs. The panel's top and bottom halves are refreshed together. Each stream beat carries one 4-bit nibble for the top half and one for the bottom half. The block places the two nibbles on two parallel output buses and pulses a shift clock once per nibble. After the last nibble of a row it raises a row latch pulse. The panel has no image memory, so the block repeats rows and frames without stopping for as long as pixels arrive.

Two configuration inputs set the refresh rate. One is a shift-clock half-period divider. The other is a count of idle clocks inserted after every latch pulse. Together they must give a frame period of 8 ms or longer, with 11.7 ms or longer (85 Hz or slower) as the target. With a continuous source, one row takes `LATCH_CYC + blank + 1 + (COLS/4)*(2*half + 3)` clocks. The frame pulse is raised during the latch pulse that closes the last row of a frame, so the panel starts its top row as that pulse ends. A polarity output flips once per frame so that no DC voltage builds up on the panel.

The pixel input is valid/ready. A beat transfers on a rising edge where both `px_valid` and `px_ready` are high. `px_ready` is high only while the shifter is waiting for its next nibble pair. The source may hold `px_valid` low for any length of time. The row then simply waits with the shift clock low. Nothing is dropped, and the row is not shortened.

Top module: `dual_scan_lcd_tcon`

## Requirements
- R1: A nibble pair is taken only on a clock edge where `px_valid` and `px_ready` are both high. `px_ready` is high only while the shift clock and the latch pulse are both low. Data on `px_upper`/`px_lower` while `px_valid` is low has no effect.
- R2: Every accepted pair shows up on `lcd_du` (top half, from `px_upper`) and `lcd_dl` (bottom half, from `px_lower`). It is held unchanged across the falling edge of `lcd_shclk` that follows. Pairs are shifted in acceptance order, with the first pair of a row being the leftmost column.
- R3: Exactly `COLS/4` rising edges of `lcd_shclk` occur between two consecutive latch pulses. If the source stalls, `lcd_shclk` stays low and `px_ready` stays high until the next beat arrives, and the row is completed, not shortened.
- R4: Each shift-clock high phase lasts `cfg_half + 1` clocks.
- R5: The latch pulse lasts exactly `LATCH_CYC` clocks, and `lcd_shclk` is low throughout it.
- R6: With an uninterrupted source, consecutive latch rising edges are `LATCH_CYC + cfg_blank + 1 + (COLS/4)*(2*cfg_half + 3)` clocks apart. This includes `cfg_blank = 0`, where shifting follows the latch with no idle clocks.
- R7: `lcd_frame` is high only during latch pulses. It is high for the first latch pulse after reset and for every `ROWS`-th latch pulse after that, which is the one ending the bottom row of a frame.
- R8: `lcd_pol` is 0 out of reset. It inverts on the clock where a frame-marked latch pulse ends, and at no other time.
- R9: While `rst_n` is low, all outputs and `px_ready` are 0. The first activity after reset is a frame-marked latch pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_half | input | DIV_W | Shift-clock half period minus one, in clocks |
| cfg_blank | input | BLANK_W | Idle clocks after each latch pulse |
| px_valid | input | 1 | Source has a nibble pair |
| px_ready | output | 1 | Block takes a nibble pair this edge |
| px_upper | input | NIB_W | Nibble for the top half |
| px_lower | input | NIB_W | Nibble for the bottom half |
| lcd_du | output | NIB_W | Top-half data bus |
| lcd_dl | output | NIB_W | Bottom-half data bus |
| lcd_shclk | output | 1 | Shift clock; the panel samples data on its fall |
| lcd_latch | output | 1 | Row latch pulse |
| lcd_frame | output | 1 | Frame start marker, high during the last row's latch |
| lcd_pol | output | 1 | Drive polarity, flipped every frame |

## Verification
The bench feeds a source stall in the middle of a row. A design that shortened the row or kept clocking would then show too few shift edges before the latch, or a nibble out of order. It also stalls exactly at a row boundary and drives junk on the data lines while valid is low. A design that took unvalidated data would shift an extra or wrong nibble. It switches between a zero blanking count, a zero divider and larger settings, and checks the latch spacing and the high-phase length after each switch. An off-by-one in either counter would stretch or shrink rows. The frame marker and polarity are tracked across several frames and from the very first latch after reset, so a marker placed on the first row instead of the last, or a polarity flip at the wrong edge, shows up as a mismatch.

// File: rtl/lcd_tcon_pkg.sv
package lcd_tcon_pkg;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_LOAD,
    SH_HIGH,
    SH_LOW
  } shift_state_t;

  typedef enum logic [1:0] {
    RS_RESET,
    RS_LATCH,
    RS_BLANK,
    RS_SHIFT
  } row_state_t;

endpackage

// File: rtl/lcd_shift_engine.sv
module lcd_shift_engine
  import lcd_tcon_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int BEATS = 160,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NIB_W-1:0] in_up,
  input  logic [NIB_W-1:0] in_lo,
  output logic [NIB_W-1:0] du,
  output logic [NIB_W-1:0] dl,
  output logic             shclk,
  output logic             row_done
);
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  shift_state_t     st;
  logic [DIV_W-1:0] cnt;
  logic [BEAT_W-1:0] beat;
  logic             last_beat;

  assign last_beat = (beat == BEAT_W'(BEATS - 1));
  assign in_ready  = (st == SH_LOAD);
  assign row_done  = (st == SH_LOW) && (cnt == '0) && last_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= SH_IDLE;
      cnt   <= '0;
      beat  <= '0;
      du    <= '0;
      dl    <= '0;
      shclk <= 1'b0;
    end else begin
      case (st)
        SH_IDLE: if (go) st <= SH_LOAD;
        SH_LOAD: begin
          // Wait here, clock low, until the source offers a pair.
          if (in_valid) begin
            du    <= in_up;
            dl    <= in_lo;
            shclk <= 1'b1;
            cnt   <= cfg_half;
            st    <= SH_HIGH;
          end
        end
        SH_HIGH: begin
          if (cnt == '0) begin
            shclk <= 1'b0;
            cnt   <= cfg_half;
            st    <= SH_LOW;
          end else begin
            cnt <= cnt - DIV_W'(1);
          end
        end
        SH_LOW: begin
          // Data stays put through the falling edge and the low phase.
          if (cnt == '0) begin
            if (last_beat) begin
              beat <= '0;
              st   <= SH_IDLE;
            end else begin
              beat <= beat + BEAT_W'(1);
              st   <= SH_LOAD;
            end
          end else begin
            cnt <= cnt - DIV_W'(1);
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_row_sequencer.sv
module lcd_row_sequencer
  import lcd_tcon_pkg::*;
#(
  parameter int ROWS      = 240,
  parameter int LATCH_CYC = 4,
  parameter int BLANK_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BLANK_W-1:0] cfg_blank,
  input  logic               row_done,
  output logic               go,
  output logic               latch,
  output logic               frame,
  output logic               pol
);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int LC_W  = $clog2(LATCH_CYC + 1);
  localparam int CNT_W = (BLANK_W > LC_W) ? BLANK_W : LC_W;

  row_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W-1:0] blank_ext;
  logic [ROW_W-1:0] row;
  logic             last_row;

  assign cnt_nx    = cnt + CNT_W'(1);
  assign blank_ext = CNT_W'(cfg_blank);
  assign last_row  = (row == ROW_W'(ROWS - 1));
  assign go        = (st == RS_SHIFT);
  assign latch     = (st == RS_LATCH);
  assign frame     = latch && last_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      // Start on the bottom row so the first latch carries the frame mark.
      st  <= RS_RESET;
      cnt <= '0;
      row <= ROW_W'(ROWS - 1);
      pol <= 1'b0;
    end else begin
      case (st)
        RS_RESET: begin
          st  <= RS_LATCH;
          cnt <= '0;
        end
        RS_LATCH: begin
          if (cnt == CNT_W'(LATCH_CYC - 1)) begin
            cnt <= '0;
            if (last_row) begin
              row <= '0;
              pol <= ~pol;
            end else begin
              row <= row + ROW_W'(1);
            end
            st <= (cfg_blank == '0) ? RS_SHIFT : RS_BLANK;
          end else begin
            cnt <= cnt_nx;
          end
        end
        RS_BLANK: begin
          if (cnt_nx >= blank_ext) begin
            cnt <= '0;
            st  <= RS_SHIFT;
          end else begin
            cnt <= cnt_nx;
          end
        end
        RS_SHIFT: if (row_done) st <= RS_LATCH;
        default:  st <= RS_RESET;
      endcase
    end
  end
endmodule

// File: rtl/dual_scan_lcd_tcon.sv
module dual_scan_lcd_tcon #(
  parameter int COLS      = 640,
  parameter int ROWS      = 240,
  parameter int NIB_W     = 4,
  parameter int DIV_W     = 8,
  parameter int BLANK_W   = 12,
  parameter int LATCH_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   cfg_half,
  input  logic [BLANK_W-1:0] cfg_blank,
  input  logic               px_valid,
  output logic               px_ready,
  input  logic [NIB_W-1:0]   px_upper,
  input  logic [NIB_W-1:0]   px_lower,
  output logic [NIB_W-1:0]   lcd_du,
  output logic [NIB_W-1:0]   lcd_dl,
  output logic               lcd_shclk,
  output logic               lcd_latch,
  output logic               lcd_frame,
  output logic               lcd_pol
);
  localparam int BEATS = COLS / NIB_W;

  logic go;
  logic row_done;

  lcd_shift_engine #(
    .NIB_W(NIB_W),
    .BEATS(BEATS),
    .DIV_W(DIV_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .cfg_half (cfg_half),
    .in_valid (px_valid),
    .in_ready (px_ready),
    .in_up    (px_upper),
    .in_lo    (px_lower),
    .du       (lcd_du),
    .dl       (lcd_dl),
    .shclk    (lcd_shclk),
    .row_done (row_done)
  );

  lcd_row_sequencer #(
    .ROWS     (ROWS),
    .LATCH_CYC(LATCH_CYC),
    .BLANK_W  (BLANK_W)
  ) u_rows (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_blank(cfg_blank),
    .row_done (row_done),
    .go       (go),
    .latch    (lcd_latch),
    .frame    (lcd_frame),
    .pol      (lcd_pol)
  );
endmodule

// File: rtl/dual_scan_lcd_tcon_chk.sv
module dual_scan_lcd_tcon_chk #(
  parameter int NIB_W = 4,
  parameter int BEATS = 160
) (
  input logic             clk,
  input logic             rst_n,
  input logic             px_ready,
  input logic [NIB_W-1:0] lcd_du,
  input logic [NIB_W-1:0] lcd_dl,
  input logic             lcd_shclk,
  input logic             lcd_latch,
  input logic             lcd_frame,
  input logic             lcd_pol
);
  localparam int CW = $clog2(BEATS + 2) + 1;

  logic          sh_q;
  logic          lat_q;
  logic          primed;
  logic [CW-1:0] rises;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= 1'b0;
      lat_q  <= 1'b0;
      primed <= 1'b0;
      rises  <= '0;
    end else begin
      sh_q  <= lcd_shclk;
      lat_q <= lcd_latch;
      if (lat_q && !lcd_latch) primed <= 1'b1;
      if (lcd_latch && !lat_q)      rises <= '0;
      else if (lcd_shclk && !sh_q)  rises <= rises + CW'(1);
    end
  end

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    px_ready |-> (!lcd_shclk && !lcd_latch));

  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_shclk) |-> ($stable(lcd_du) && $stable(lcd_dl)));

  p_data_moves_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((lcd_du != $past(lcd_du)) || (lcd_dl != $past(lcd_dl))) |-> $rose(lcd_shclk));

  p_row_beats_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_latch && !lat_q && primed) |-> (rises == CW'(BEATS)));

  p_quiet_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_latch |-> !lcd_shclk);

  p_frame_in_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_frame |-> lcd_latch);

  p_pol_turn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lcd_pol) |-> $fell(lcd_frame));
endmodule

bind dual_scan_lcd_tcon dual_scan_lcd_tcon_chk #(
  .NIB_W(NIB_W),
  .BEATS(COLS / NIB_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .px_ready (px_ready),
  .lcd_du   (lcd_du),
  .lcd_dl   (lcd_dl),
  .lcd_shclk(lcd_shclk),
  .lcd_latch(lcd_latch),
  .lcd_frame(lcd_frame),
  .lcd_pol  (lcd_pol)
);

// File: tb/test_dual_scan_lcd_tcon.sv
`timescale 1ns/1ps
module test_dual_scan_lcd_tcon;
  localparam int COLS = 16, ROWS = 4, NIB_W = 4, DIV_W = 4, BLANK_W = 4, LATCH_CYC = 2;
  localparam int BEATS = COLS / NIB_W;
  localparam int FRAME_BEATS = BEATS * ROWS;

  logic clk = 1'b0;
  logic rst_n;
  logic [DIV_W-1:0] cfg_half;
  logic [BLANK_W-1:0] cfg_blank;
  logic px_valid, px_ready;
  logic [NIB_W-1:0] px_upper, px_lower, lcd_du, lcd_dl;
  logic lcd_shclk, lcd_latch, lcd_frame, lcd_pol;

  always #2.5 clk = ~clk;

  dual_scan_lcd_tcon #(
    .COLS(COLS), .ROWS(ROWS), .NIB_W(NIB_W), .DIV_W(DIV_W),
    .BLANK_W(BLANK_W), .LATCH_CYC(LATCH_CYC)
  ) i_dual_scan_lcd_tcon (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_blank(cfg_blank),
    .px_valid(px_valid), .px_ready(px_ready), .px_upper(px_upper), .px_lower(px_lower),
    .lcd_du(lcd_du), .lcd_dl(lcd_dl), .lcd_shclk(lcd_shclk), .lcd_latch(lcd_latch),
    .lcd_frame(lcd_frame), .lcd_pol(lcd_pol)
  );

  int checks = 0, fails = 0;
  logic [7:0] sb[$];
  bit meas_en = 1'b1;
  int skip = 0, exp_period = 0;
  int latches = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: called at a falling edge; pushes the expected pair once the design accepts it.
  task automatic send(input logic [3:0] u, input logic [3:0] l);
    px_valid = 1'b1; px_upper = u; px_lower = l;
    while (!px_ready) @(negedge clk);
    sb.push_back({u, l});
    @(negedge clk);
  endtask

  // Source dry with junk on the data lines; optionally check the shifter waits idle.
  task automatic stall(input int n, input bit chk);
    bit bad = 1'b0;
    px_valid = 1'b0; px_upper = 4'hA; px_lower = 4'h5;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (chk && k >= 2 * int'(cfg_half) + 4 && (lcd_shclk || !px_ready)) bad = 1'b1;
    end
    if (chk) check(!bad, "R3", "shift clock idle and ready high during stall", int'(bad), 0);
  endtask

  // Monitor / scoreboard
  bit sh_p = 0, lat_p = 0, fr_seen = 0, exp_pol = 0;
  int cyc = 0, rises = 0, hi_len = 0, lat_len = 0, last_lat = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      sh_p = 0; lat_p = 0; exp_pol = 0; rises = 0; latches = 0;
    end else begin
      cyc++;
      if (lcd_shclk && !sh_p) begin rises++; hi_len = 1; end
      else if (lcd_shclk) hi_len++;
      if (!lcd_shclk && sh_p) begin
        if (sb.size() == 0) check(0, "R2", "shift edge with no pending pair", {lcd_du, lcd_dl}, -1);
        else begin
          logic [7:0] e;
          e = sb.pop_front();
          check({lcd_du, lcd_dl} == e, "R2", "nibble pair at shift fall", {lcd_du, lcd_dl}, e);
        end
        if (meas_en && skip == 0)
          check(hi_len == int'(cfg_half) + 1, "R4", "shift clock high length", hi_len, int'(cfg_half) + 1);
      end
      if (lcd_latch && lcd_shclk) check(0, "R5", "shift clock during latch", 1, 0);
      if (lcd_latch && !lat_p) begin
        check(lcd_frame == ((latches % ROWS) == 0), "R7", "frame mark on latch",
              int'(lcd_frame), int'((latches % ROWS) == 0));
        if (latches > 0) begin
          check(rises == BEATS, "R3", "shift edges per row", rises, BEATS);
          if (meas_en && skip == 0)
            check(cyc - last_lat == exp_period, "R6", "row period", cyc - last_lat, exp_period);
          if (skip > 0) skip--;
        end
        rises = 0; last_lat = cyc; latches++; lat_len = 1; fr_seen = lcd_frame;
      end else if (lcd_latch) lat_len++;
      if (!lcd_latch && lat_p) begin
        check(lat_len == LATCH_CYC, "R5", "latch width", lat_len, LATCH_CYC);
        if (fr_seen) exp_pol = ~exp_pol;
        check(lcd_pol == exp_pol, "R8", "polarity after latch", int'(lcd_pol), int'(exp_pol));
      end else if (lcd_pol != exp_pol) begin
        check(0, "R8", "polarity changed outside frame latch", int'(lcd_pol), int'(exp_pol));
      end
      sh_p = lcd_shclk; lat_p = lcd_latch;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R3", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; px_valid = 1'b0; px_upper = '0; px_lower = '0;
    cfg_half = 4'd1; cfg_blank = 4'd2;
    exp_period = LATCH_CYC + 2 + 1 + BEATS * (2 * 1 + 3);
    repeat (4) @(negedge clk);
    check({lcd_du, lcd_dl, lcd_shclk, lcd_latch, lcd_frame, lcd_pol, px_ready} == '0,
          "R9", "outputs during reset", {lcd_du, lcd_dl, lcd_shclk, lcd_latch, lcd_frame, lcd_pol, px_ready}, 0);
    rst_n = 1'b1;

    // Counting pattern, two frames, continuous source (R1, R2, R6, R7, R8)
    for (int i = 0; i < 2 * FRAME_BEATS; i++) send(i[3:0], ~i[3:0]);

    // Zero divider and zero blanking (R4, R6)
    cfg_half = 4'd0; cfg_blank = 4'd0; skip = 2;
    exp_period = LATCH_CYC + 0 + 1 + BEATS * 3;
    for (int i = 0; i < FRAME_BEATS; i++) send(i[0] ? 4'hF : 4'h0, i[0] ? 4'h0 : 4'hF);

    // Slower clock, longer blanking, random data
    cfg_half = 4'd2; cfg_blank = 4'd3; skip = 2;
    exp_period = LATCH_CYC + 3 + 1 + BEATS * (2 * 2 + 3);
    for (int i = 0; i < FRAME_BEATS; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      send(r[7:4], r[3:0]);
    end

    // Source stalls mid-row and at a row boundary (R1, R3)
    meas_en = 1'b0;
    send(4'h1, 4'hE); send(4'h2, 4'hD);
    stall(20, 1'b1);
    send(4'h3, 4'hC); send(4'h4, 4'hB);
    for (int i = 0; i < BEATS; i++) send(4'(i + 6), 4'(9 - i));
    stall(15, 1'b0);
    for (int i = 0; i < 2 * BEATS; i++) send(4'(i * 3), 4'(i * 5));

    px_valid = 1'b0;
    for (int k = 0; k < 2000 && sb.size() != 0; k++) @(negedge clk);
    repeat (60) @(negedge clk);
    check(sb.size() == 0, "R2", "all accepted pairs shifted", sb.size(), 0);
    check(latches == 5 * ROWS + 1, "R3", "latch count, rows completed", latches, 5 * ROWS + 1);
    check(!lcd_shclk && px_ready, "R1", "waiting for data at end", int'(px_ready), 1);
    finish_run();
  end
endmodule